// File: doc/BRIEF.md
# SPI Interrupt and TX Watermark Register Unit

This block is the interrupt control register set of an SPI controller. It gathers four conditions reported by the SPI engine: a mode-fault event pulse, the TX FIFO fill level, a TX-full flag and an RX-not-empty flag. It presents them as a status word and combines them with an interrupt mask to drive one registered interrupt line. The shifting engine and the FIFO storage sit outside this block.

Software reaches the unit through a simple single-cycle read/write bus. The mask is never written directly. One write-only offset sets mask bits and another clears them, and the mask itself is read back at its own read-only offset. The mode fault is a sticky event that stays latched until software writes a one to its status position. The other three status bits follow their FIFO conditions live. The TX condition compares the TX fill level with a programmable watermark.

Top module: `spi_irq_regs`

## Requirements
- R1: After reset the mask reads 0, the watermark (offset 0x28) reads 1, the irq output is 0, and with the TX level at 0, no TX-full, no RX data and no fault, the status (offset 0x04) reads 0x04.
- R2: Status, mask, enable and disable share one 7-bit layout: bit 1 mode fault, bit 2 TX level below watermark, bit 3 TX full, bit 4 RX not empty. Bits 0, 5 and 6 always read 0 in status and mask, and enable writes to them have no effect.
- R3: A write to offset 0x08 sets every mask bit written as 1 and leaves the bits written as 0 unchanged. The mask reads back at offset 0x10.
- R4: A write to offset 0x0C clears every mask bit written as 1 and leaves the bits written as 0 unchanged.
- R5: A one-cycle mode-fault pulse sets status bit 1, which stays set until a status write with bit 1 set. Status writes with bit 1 at 0 leave it set.
- R6: A mode-fault pulse in the same cycle as a status write that clears bit 1 leaves bit 1 set.
- R7: Status bit 2 is 1 exactly when the TX level is below the watermark, which is written and read at offset 0x28 and may hold any value up to the FIFO depth of 128.
- R8: Status bits 3 and 4 follow the TX-full and RX-not-empty inputs live, and status writes do not change them.
- R9: irq is the OR of status AND mask, registered: it reflects the values present one clock earlier.
- R10: Reads of offsets 0x08, 0x0C and any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| modf_pulse | input | 1 | Mode-fault event, one cycle |
| tx_level | input | 8 | TX FIFO fill level, 0 to 128 |
| tx_full | input | 1 | TX FIFO full |
| rx_not_empty | input | 1 | RX FIFO holds data |
| irq | output | 1 | Registered interrupt request |

## Verification
The case that needs care is a mode-fault pulse arriving in the same clock as a software write-one that clears the same sticky bit. The bench drives the pulse and the status write on the same falling edge and releases both on the next one. It then reads the status and expects bit 1 still set, then clears it alone and expects 0. A second overlap is a mask change landing in the same cycle as a status change. Here the bench checks that irq keeps its old value on the edge of the change and takes the new value one edge later.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
   localparam int IRQ_W    = 7;
   localparam int B_MODF   = 1;
   localparam int B_TXLOW  = 2;
   localparam int B_TXFULL = 3;
   localparam int B_RXNE   = 4;

   localparam logic [7:0] OFS_STAT = 8'h04;
   localparam logic [7:0] OFS_SET  = 8'h08;
   localparam logic [7:0] OFS_CLR  = 8'h0C;
   localparam logic [7:0] OFS_MASK = 8'h10;
   localparam logic [7:0] OFS_WM   = 8'h28;

   localparam logic [IRQ_W-1:0] STICKY_BITS = 7'b0000010;
   localparam logic [IRQ_W-1:0] LIVE_BITS   = 7'b0011100;
   localparam logic [IRQ_W-1:0] IMPL_BITS   = STICKY_BITS | LIVE_BITS;
endpackage

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
   parameter int                 W      = 7,
   parameter logic [W-1:0]       STICKY = '0,
   parameter logic [W-1:0]       LIVE   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ev_set,
   input  logic [W-1:0] live_in,
   input  logic [W-1:0] w1c,
   output logic [W-1:0] stat
);
   initial begin
      if ((STICKY & LIVE) != '0) $error("status bit cannot be both sticky and live");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (STICKY[i]) begin : g_sticky
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= ev_set[i] | (q & ~w1c[i]);
         end
         assign stat[i] = q;

         // R5: a latched event survives until a write-one hits it
         a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (q && !w1c[i]) |=> q);
         // R6: an event wins over a same-cycle clear
         a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ev_set[i] |=> q);
      end else if (LIVE[i]) begin : g_live
         assign stat[i] = live_in[i];
      end else begin : g_rsvd
         assign stat[i] = 1'b0;
      end
   end
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
   parameter int           W    = 7,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_v,
   input  logic [W-1:0] clr_v,
   output logic [W-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask <= '0;
      else        mask <= ((mask | set_v) & ~clr_v) & IMPL;
   end

   // R3: written-one positions of an enable write end up set
   a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v == '0) |=> ((mask & $past(set_v) & IMPL) == ($past(set_v) & IMPL)));
   // R4: written-one positions of a disable write end up clear
   a_r4_clr: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((mask & $past(clr_v)) == '0));
   // R3/R4: no write, no change
   a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v == '0 && clr_v == '0) |=> $stable(mask));
endmodule

// File: rtl/spi_irq_wmark.sv
module spi_irq_wmark #(
   parameter int DEPTH = 128,
   parameter int LW    = $clog2(DEPTH + 1),
   parameter int RST   = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [LW-1:0] wdata,
   input  logic [LW-1:0] level,
   output logic [LW-1:0] wm,
   output logic          below
);
   initial begin
      if (DEPTH < 2)                  $error("FIFO depth too small");
      if (RST < 0 || RST > DEPTH)     $error("watermark reset out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  wm <= LW'(RST);
      else if (wr) wm <= wdata;
   end

   assign below = (level < wm);

   // R7: a watermark write is taken on the next edge
   a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (wm == $past(wdata)));
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
   import spi_irq_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 128,
   parameter int WM_RESET   = 1,
   localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              modf_pulse,
   input  logic [LVL_W-1:0]  tx_level,
   input  logic              tx_full,
   input  logic              rx_not_empty,
   output logic              irq
);
   initial begin
      if (ADDR_W < 6)             $error("address too narrow for the map");
      if (DATA_W < IRQ_W)         $error("data bus narrower than status");
      if (DATA_W < LVL_W)         $error("data bus narrower than watermark");
   end

   logic             sel_stat, sel_set, sel_clr, sel_mask, sel_wm;
   logic [IRQ_W-1:0] wfield, ev_vec, live_vec, stat, mask;
   logic [LVL_W-1:0] wm;
   logic             txlow, pending;

   assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
   assign sel_set  = (bus_addr == ADDR_W'(OFS_SET));
   assign sel_clr  = (bus_addr == ADDR_W'(OFS_CLR));
   assign sel_mask = (bus_addr == ADDR_W'(OFS_MASK));
   assign sel_wm   = (bus_addr == ADDR_W'(OFS_WM));
   assign wfield   = bus_wdata[IRQ_W-1:0];

   spi_irq_wmark #(.DEPTH(FIFO_DEPTH), .LW(LVL_W), .RST(WM_RESET)) u_wm (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_wr & sel_wm),
      .wdata (bus_wdata[LVL_W-1:0]),
      .level (tx_level),
      .wm    (wm),
      .below (txlow)
   );

   always_comb begin
      ev_vec           = '0;
      ev_vec[B_MODF]   = modf_pulse;
      live_vec         = '0;
      live_vec[B_TXLOW]  = txlow;
      live_vec[B_TXFULL] = tx_full;
      live_vec[B_RXNE]   = rx_not_empty;
   end

   spi_irq_status #(.W(IRQ_W), .STICKY(STICKY_BITS), .LIVE(LIVE_BITS)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_set  (ev_vec),
      .live_in (live_vec),
      .w1c     (bus_wr && sel_stat ? wfield : '0),
      .stat    (stat)
   );

   spi_irq_mask #(.W(IRQ_W), .IMPL(IMPL_BITS)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .set_v (bus_wr && sel_set ? wfield : '0),
      .clr_v (bus_wr && sel_clr ? wfield : '0),
      .mask  (mask)
   );

   assign pending = |(stat & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= pending;
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_stat)      bus_rdata = DATA_W'(stat);
      else if (sel_mask) bus_rdata = DATA_W'(mask);
      else if (sel_wm)   bus_rdata = DATA_W'(wm);
   end

   // R9: nothing pending means the line is low one cycle later
   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !pending |=> !irq);
   // R9: a pending enabled cause raises the line one cycle later
   a_r9_raise: assert property (@(posedge clk) disable iff (!rst_n)
      pending |=> irq);
   // R2: reserved positions never show in status or mask
   a_r2_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat | mask) & ~IMPL_BITS) == '0);
endmodule

// File: tb/spi_irq_regs_tb.sv
module spi_irq_regs_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        modf_pulse = 1'b0;
   logic [7:0]  tx_level = '0;
   logic        tx_full = 1'b0;
   logic        rx_not_empty = 1'b0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_irq_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .modf_pulse(modf_pulse),
      .tx_level(tx_level), .tx_full(tx_full), .rx_not_empty(rx_not_empty),
      .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FIFO FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pulse_modf();
      @(negedge clk);
      modf_pulse = 1'b1;
      @(negedge clk);
      modf_pulse = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 irq", {31'b0, irq}, 32'h0);
      rd(8'h04, d); chk("R1 status", d, 32'h04);
      rd(8'h10, d); chk("R1 mask", d, 32'h0);
      rd(8'h28, d); chk("R1 watermark", d, 32'h1);
      @(negedge clk); tx_level = 8'd8;
      rd(8'h04, d); chk("R7 level above wm", d, 32'h0);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      wr(8'h08, 32'h12); rd(8'h10, d); chk("R3 set", d, 32'h12);
      wr(8'h08, 32'h04); rd(8'h10, d); chk("R3 zeros keep", d, 32'h16);
      wr(8'h08, 32'h61); rd(8'h10, d); chk("R2 reserved set ignored", d, 32'h16);
      wr(8'h0C, 32'h10); rd(8'h10, d); chk("R4 clear", d, 32'h06);
      wr(8'h0C, 32'h00); rd(8'h10, d); chk("R4 zeros keep", d, 32'h06);
      wr(8'h0C, 32'h7F); rd(8'h10, d); chk("R4 clear all", d, 32'h0);
   endtask

   task automatic t_wo_reads();
      logic [31:0] d;
      rd(8'h08, d); chk("R10 enable read", d, 32'h0);
      rd(8'h0C, d); chk("R10 disable read", d, 32'h0);
      rd(8'h3C, d); chk("R10 unmapped read", d, 32'h0);
   endtask

   task automatic t_wmark();
      logic [31:0] d;
      wr(8'h28, 32'd4);
      @(negedge clk); tx_level = 8'd3;
      rd(8'h04, d); chk("R7 below", d, 32'h04);
      @(negedge clk); tx_level = 8'd4;
      rd(8'h04, d); chk("R7 equal not below", d, 32'h0);
      wr(8'h28, 32'd128);
      rd(8'h28, d); chk("R7 wm readback", d, 32'd128);
      @(negedge clk); tx_level = 8'd127;
      rd(8'h04, d); chk("R7 127 below 128", d, 32'h04);
      @(negedge clk); tx_level = 8'd128;
      rd(8'h04, d); chk("R7 full level", d, 32'h0);
      wr(8'h28, 32'd1);
      @(negedge clk); tx_level = 8'd8;
   endtask

   task automatic t_live();
      logic [31:0] d;
      @(negedge clk); tx_full = 1'b1; rx_not_empty = 1'b1;
      rd(8'h04, d); chk("R8 live set", d, 32'h18);
      wr(8'h04, 32'h18);
      rd(8'h04, d); chk("R8 write-one no effect", d, 32'h18);
      @(negedge clk); tx_full = 1'b0;
      rd(8'h04, d); chk("R8 txfull drop", d, 32'h10);
      @(negedge clk); rx_not_empty = 1'b0;
      rd(8'h04, d); chk("R8 rx drained", d, 32'h0);
   endtask

   task automatic t_sticky();
      logic [31:0] d;
      pulse_modf();
      rd(8'h04, d); chk("R5 fault latched", d, 32'h02);
      repeat (3) @(negedge clk);
      rd(8'h04, d); chk("R5 fault held", d, 32'h02);
      wr(8'h04, 32'h7D);
      rd(8'h04, d); chk("R5 other ones keep", d, 32'h02);
      wr(8'h04, 32'h02);
      rd(8'h04, d); chk("R5 cleared", d, 32'h0);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      pulse_modf();
      @(negedge clk);
      bus_addr = 8'h04; bus_wr = 1'b1; bus_wdata = 32'h02; modf_pulse = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0; modf_pulse = 1'b0;
      rd(8'h04, d); chk("R6 set wins", d, 32'h02);
      wr(8'h04, 32'h02);
      rd(8'h04, d); chk("R6 later clear", d, 32'h0);
   endtask

   task automatic t_irq();
      wr(8'h08, 32'h02);
      chk("R9 masked-in idle", {31'b0, irq}, 32'h0);
      pulse_modf();
      chk("R9 one-cycle lag", {31'b0, irq}, 32'h0);
      @(negedge clk);
      chk("R9 raised", {31'b0, irq}, 32'h1);
      wr(8'h04, 32'h02);
      chk("R9 old value on clear edge", {31'b0, irq}, 32'h1);
      @(negedge clk);
      chk("R9 dropped", {31'b0, irq}, 32'h0);
      @(negedge clk); rx_not_empty = 1'b1;
      repeat (2) @(negedge clk);
      chk("R9 masked cause", {31'b0, irq}, 32'h0);
      wr(8'h08, 32'h10);
      chk("R9 mask edge lag", {31'b0, irq}, 32'h0);
      @(negedge clk);
      chk("R9 unmasked cause", {31'b0, irq}, 32'h1);
      @(negedge clk); rx_not_empty = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 cause gone", {31'b0, irq}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_wo_reads();
      t_wmark();
      t_live();
      t_sticky();
      t_collide();
      t_irq();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule